// File: doc/BRIEF.md
# Serial Display Command/Data Receiver

This block takes bytes from a host over a write-only serial link and tags each one as a display-data byte or a command byte. A static two-bit interface select input picks the link variant. In the four-wire variant a separate data/command line, sampled on the last clock of each byte, decides the tag. In the three-wire variant there is no such line. Instead, a two-byte length command (0xE8 followed by a count) announces how many display-data bytes follow. After that many bytes, the stream goes back to commands.

The serial clock, serial data, chip select and data/command line are brought into the system clock domain through a synchronizer. Rising edges of the serial clock are detected there. Each finished byte appears on the output as a one-cycle strobe, together with the byte and its tag. Byte alignment depends only on the bit counter. A glitch on the serial clock therefore needs the synchronous hardware reset to recover. Raising chip select between bytes also realigns the counter.

Top module: `serial_cmd_rx`

## Requirements
- R1: While chip select is low, each rising serial clock edge shifts one data bit into the byte, most significant bit first. The eighth edge completes the byte and presents it on `rx_byte`.
- R2: In four-wire mode (`if_sel` = 2'b01 or 2'b10), the data/command line is taken on the eighth edge. A high value tags the byte as data (`rx_is_data` = 1) and a low value tags it as a command (`rx_is_data` = 0).
- R3: A high chip select clears the bit count, so a partial byte is discarded and nothing is emitted for it. The next byte is assembled from its first bit.
- R4: In three-wire mode (`if_sel` = 2'b00), a command byte of 0xE8 and the byte after it are both emitted tagged as command.
- R5: In three-wire mode, the count byte value V announces V+1 data bytes (0x00 gives 1, 0xFF gives 256). Exactly that many following bytes are tagged as data.
- R6: In three-wire mode, the byte after the last announced data byte is tagged as a command. Bytes with no length command in force are commands.
- R7: In four-wire mode, 0xE8 has no length effect. The bytes after it are still tagged by the data/command line.
- R8: With `if_sel` = 2'b11 no serial variant is active, and no byte is emitted.
- R9: The synchronous active-high reset clears the bit count and any pending length state. The next full byte is assembled from its first bit and, in three-wire mode, tagged as a command.
- R10: `rx_vld` is a registered single-cycle strobe. `rx_vld`, `rx_byte` and `rx_is_data` are 0 after reset.
- R11: In three-wire mode the data/command line is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| if_sel | input | 2 | Interface select: 00 three-wire, 01/10 four-wire, 11 none (static) |
| ser_clk | input | 1 | Serial clock from host |
| ser_dat | input | 1 | Serial data from host |
| ser_cs_n | input | 1 | Chip select, active low |
| ser_dc | input | 1 | Data/command line (four-wire only) |
| rx_vld | output | 1 | One-cycle strobe per received byte |
| rx_byte | output | 8 | Received byte |
| rx_is_data | output | 1 | 1 = display data, 0 = command |

## Verification
The assertions check four things on every cycle:
- In three-wire mode, the remaining-count register agrees with the tracker state: it is nonzero while data bytes are pending and zero otherwise.
- Four-wire mode forces the tracker back to the command state.
- A chip-select deassertion clears the bit counter.
- The output strobe never lasts two cycles, and no strobe follows a cycle in which no variant was selected.

Only the scoreboard scenarios can show whether the values are right. These cover MSB-first assembly, the tag for each byte, the exact count boundaries at one and 256 bytes, partial-byte discard, and recovery after reset in the middle of a length run.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [1:0] {
    LS_CMD  = 2'd0,
    LS_ARG  = 2'd1,
    LS_DATA = 2'd2
  } len_state_e;

  typedef enum logic [1:0] {
    IF_3W   = 2'b00,
    IF_4W_A = 2'b01,
    IF_4W_B = 2'b10,
    IF_NONE = 2'b11
  } if_sel_e;
endpackage

// File: rtl/srx_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous inputs.
module srx_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[gi] <= RST_VAL;
          else     stage_q[gi] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[gi] <= RST_VAL;
          else     stage_q[gi] <= stage_q[gi-1];
        end
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/srx_deser.sv
// Bit counter and shift register; emits a completed byte and the sampled D/C level.
module srx_deser #(
  parameter int BW = 8,
  localparam int CW = $clog2(BW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rise,
  input  logic          sd,
  input  logic          cs_n,
  input  logic          dc,
  output logic          done,
  output logic [BW-1:0] data,
  output logic          dc_out
);
  logic [CW-1:0] cnt;
  logic [BW-1:0] shreg;
  logic [BW-1:0] next_sh;

  assign next_sh = {shreg[BW-2:0], sd};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      shreg  <= '0;
      done   <= 1'b0;
      data   <= '0;
      dc_out <= 1'b0;
    end else begin
      done <= 1'b0;
      if (cs_n) begin
        cnt <= '0;
      end else if (rise) begin
        shreg <= next_sh;
        if (cnt == CW'(BW-1)) begin
          done   <= 1'b1;
          data   <= next_sh;
          dc_out <= dc;
          cnt    <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R3: a high chip select leaves the bit counter at zero
  a_r3_cnt_cleared: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (cnt == '0));
endmodule

// File: rtl/srx_len_tracker.sv
// Classifies bytes: D/C line in four-wire mode, length countdown in three-wire mode.
module srx_len_tracker
  import srx_pkg::*;
#(
  parameter int          BW      = 8,
  parameter logic [BW-1:0] LEN_CMD = 8'hE8,
  localparam int RW = BW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          three_wire,
  input  logic          enable,
  input  logic          in_vld,
  input  logic [BW-1:0] in_byte,
  input  logic          in_dc,
  output logic          out_vld,
  output logic [BW-1:0] out_byte,
  output logic          out_is_data
);
  len_state_e    state;
  logic [RW-1:0] rem;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= LS_CMD;
      rem         <= '0;
      out_vld     <= 1'b0;
      out_byte    <= '0;
      out_is_data <= 1'b0;
    end else begin
      out_vld <= 1'b0;
      if (!three_wire) begin
        state <= LS_CMD;
        rem   <= '0;
      end
      if (in_vld && enable) begin
        out_vld  <= 1'b1;
        out_byte <= in_byte;
        if (!three_wire) begin
          out_is_data <= in_dc;
        end else begin
          unique case (state)
            LS_CMD: begin
              out_is_data <= 1'b0;
              if (in_byte == LEN_CMD) state <= LS_ARG;
            end
            LS_ARG: begin
              out_is_data <= 1'b0;
              rem         <= {1'b0, in_byte} + 1'b1;
              state       <= LS_DATA;
            end
            LS_DATA: begin
              out_is_data <= 1'b1;
              rem         <= rem - 1'b1;
              if (rem == RW'(1)) state <= LS_CMD;
            end
            default: state <= LS_CMD;
          endcase
        end
      end
    end
  end

  // R5: while data bytes are pending the remaining count is nonzero
  a_r5_rem_nonzero: assert property (@(posedge clk) disable iff (rst)
    (state == LS_DATA) |-> (rem != '0));
  // R6: outside a data run no count is left over
  a_r6_rem_idle: assert property (@(posedge clk) disable iff (rst)
    (state != LS_DATA) |-> (rem == '0));
  // R7: four-wire mode keeps the tracker in the command state
  a_r7_4w_no_len: assert property (@(posedge clk) disable iff (rst)
    !three_wire |=> (state == LS_CMD));
endmodule

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx
  import srx_pkg::*;
#(
  parameter int BW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [BW-1:0] LEN_CMD = 8'hE8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    if_sel,
  input  logic          ser_clk,
  input  logic          ser_dat,
  input  logic          ser_cs_n,
  input  logic          ser_dc,
  output logic          rx_vld,
  output logic [BW-1:0] rx_byte,
  output logic          rx_is_data
);
  localparam int NSIG = 4;

  logic [NSIG-1:0] sync_out;
  logic            sclk_s, sdat_s, cs_n_s, dc_s;
  logic            sclk_d;
  logic            rise;
  logic            b_done, b_dc;
  logic [BW-1:0]   b_data;
  logic            three_wire, active;

  srx_sync #(
    .W       (NSIG),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (4'b0100)
  ) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({ser_clk, ser_dat, ser_cs_n, ser_dc}),
    .dout (sync_out)
  );

  assign {sclk_s, sdat_s, cs_n_s, dc_s} = sync_out;

  always_ff @(posedge clk) begin
    if (rst) sclk_d <= 1'b0;
    else     sclk_d <= sclk_s;
  end

  assign rise = sclk_s & ~sclk_d;

  srx_deser #(.BW(BW)) u_deser (
    .clk    (clk),
    .rst    (rst),
    .rise   (rise),
    .sd     (sdat_s),
    .cs_n   (cs_n_s),
    .dc     (dc_s),
    .done   (b_done),
    .data   (b_data),
    .dc_out (b_dc)
  );

  assign three_wire = (if_sel == IF_3W);
  assign active     = (if_sel != IF_NONE);

  srx_len_tracker #(.BW(BW), .LEN_CMD(LEN_CMD)) u_len (
    .clk         (clk),
    .rst         (rst),
    .three_wire  (three_wire),
    .enable      (active),
    .in_vld      (b_done),
    .in_byte     (b_data),
    .in_dc       (b_dc),
    .out_vld     (rx_vld),
    .out_byte    (rx_byte),
    .out_is_data (rx_is_data)
  );

  // R10: the byte strobe lasts a single cycle
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rx_vld |=> !rx_vld);
  // R8: no strobe follows a cycle in which no serial variant was selected
  a_r8_none_silent: assert property (@(posedge clk) disable iff (rst)
    rx_vld |-> ($past(if_sel) != IF_NONE));
endmodule

// File: tb/sim_serial_cmd_rx.sv
module sim_serial_cmd_rx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] if_sel = 2'b01;
  logic       ser_clk = 1'b0, ser_dat = 1'b0, ser_cs_n = 1'b1, ser_dc = 1'b0;
  logic       rx_vld;
  logic [7:0] rx_byte;
  logic       rx_is_data;

  always #10 clk = ~clk;

  serial_cmd_rx u0 (
    .clk(clk), .rst(rst), .if_sel(if_sel),
    .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_cs_n(ser_cs_n), .ser_dc(ser_dc),
    .rx_vld(rx_vld), .rx_byte(rx_byte), .rx_is_data(rx_is_data)
  );

  int n_chk = 0, n_bad = 0, n_vld = 0;
  logic [8:0] exp_q[$];
  string      tag_q[$];

  // reference model of the three-wire length state
  int ref_st  = 0;
  int ref_rem = 0;
  bit three_w = 1'b0;
  bit emit_on = 1'b1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && rx_vld) begin
      n_vld++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected byte", {rx_is_data, rx_byte}, 0);
      end else begin
        logic [8:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({rx_is_data, rx_byte} == e, t, {rx_is_data, rx_byte}, e);
      end
    end
  end

  task automatic do_reset();
    ser_clk = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    ref_st = 0;
    ref_rem = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_bit(input bit b, input bit dc);
    ser_dat = b;
    ser_dc  = dc;
    repeat (4) @(negedge clk);
    ser_clk = 1'b1;
    repeat (4) @(negedge clk);
    ser_clk = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input bit dc, input string tag);
    bit is_d;
    if (!three_w) begin
      is_d = dc;
    end else begin
      case (ref_st)
        0: begin is_d = 0; if (b == 8'hE8) ref_st = 1; end
        1: begin is_d = 0; ref_rem = int'(b) + 1; ref_st = 2; end
        default: begin is_d = 1; ref_rem--; if (ref_rem == 0) ref_st = 0; end
      endcase
    end
    if (emit_on) begin
      exp_q.push_back({is_d, b});
      tag_q.push_back(tag);
    end
    ser_cs_n = 1'b0;
    for (int i = 7; i >= 0; i--) send_bit(b[i], dc);
  endtask

  task automatic drain();
    repeat (12) @(negedge clk);
    check(exp_q.size() == 0, "R1 pending bytes", exp_q.size(), 0);
  endtask

  initial begin
    int wd = 0;
    while (wd < 190000) begin @(posedge clk); wd++; end
    check(1'b0, "watchdog", wd, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int pv;
    void'($urandom(7));
    do_reset();
    // R10 reset state
    check({rx_vld, rx_is_data, rx_byte} == 10'd0, "R10 reset outputs", {rx_vld, rx_is_data, rx_byte}, 0);

    // four-wire mode
    if_sel = 2'b01; three_w = 0;
    send(8'hA5, 1, "R1 R2 data byte");
    send(8'h3C, 0, "R2 command byte");
    send(8'hE8, 0, "R7 len cmd in 4w");
    send(8'h02, 0, "R7 arg stays cmd");
    send(8'h11, 1, "R7 data by pin");
    send(8'h22, 0, "R7 cmd by pin");
    for (int i = 0; i < 20; i++) send(8'($urandom), 1'($urandom), "R2 random 4w");
    if_sel = 2'b10;
    for (int i = 0; i < 6; i++) send(8'($urandom), 1'($urandom), "R2 random 4w alt");
    ser_cs_n = 1'b1; drain();

    // R3 partial byte then chip select high
    ser_cs_n = 1'b0;
    send_bit(1, 1); send_bit(0, 1); send_bit(1, 1);
    ser_cs_n = 1'b1; repeat (8) @(negedge clk);
    send(8'h5A, 1, "R3 after discard");
    ser_cs_n = 1'b1; drain();

    // three-wire mode
    if_sel = 2'b00; three_w = 1; do_reset();
    send(8'h40, 1, "R6 R11 cmd with dc high");
    send(8'hE8, 0, "R4 len cmd");
    send(8'h02, 0, "R4 len arg");
    send(8'h81, 0, "R5 R11 data dc low");
    send(8'h82, 0, "R5 data");
    send(8'h83, 1, "R5 data last");
    send(8'hAF, 0, "R6 back to cmd");
    send(8'hE8, 0, "R4 len cmd");
    send(8'h00, 0, "R5 arg zero");
    send(8'h99, 0, "R5 single data");
    send(8'hE8, 0, "R6 cmd after single");
    send(8'hFF, 0, "R4 arg ff");
    for (int i = 0; i < 256; i++) send(8'($urandom), 1'($urandom), "R5 256 data");
    send(8'hE8, 0, "R6 cmd after 256");
    send(8'h01, 0, "R4 arg");
    send(8'hE8, 0, "R5 E8 as data");
    send(8'h55, 0, "R5 data");
    for (int i = 0; i < 60; i++) begin
      if ($urandom_range(0, 5) == 0 && ref_st == 0) begin
        send(8'hE8, 1'($urandom), "R4 random len");
        pv = $urandom_range(0, 6);
        send(8'(pv), 1'($urandom), "R4 random arg");
      end else begin
        send(8'($urandom), 1'($urandom), "R5 R6 random 3w");
      end
    end
    ser_cs_n = 1'b1; drain();

    // R9 reset in the middle of a length run and of a byte
    do_reset();
    send(8'hE8, 0, "R9 len cmd");
    send(8'h09, 0, "R9 arg");
    send(8'h12, 0, "R9 data");
    send(8'h34, 0, "R9 data");
    send_bit(1, 0); send_bit(1, 0);
    repeat (12) @(negedge clk);
    do_reset();
    send(8'h56, 0, "R9 cmd after reset");
    ser_cs_n = 1'b1; drain();

    // R8 no interface selected
    do_reset();
    if_sel = 2'b11; emit_on = 0; pv = n_vld;
    send(8'h77, 1, "R8"); send(8'hE8, 0, "R8"); send(8'h01, 1, "R8");
    ser_cs_n = 1'b1; repeat (12) @(negedge clk);
    check(n_vld == pv, "R8 no strobe", n_vld - pv, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule